// File: doc/BRIEF.md
# Command-Word Filter and Reply Timer

This block sits behind the word decoder of a simulated remote terminal and bus monitor. Every received command word is looked up, all sixteen bits of it, in a table that the host writes. The two-bit entry found there says whether the message that follows is dropped, recorded, answered, or both recorded and answered. Because the key is the complete command word, two commands to the same terminal and subaddress that differ only in direction or word count can be handled differently.

When a message is to be answered, the block waits for the end-of-message event, which marks the mid-parity crossing of the last received word. It then counts a programmable reply delay of 2 µs to 33 µs in 0.5 µs steps (20 to 330 clocks at 10 MHz) and issues a one-clock reply-start strobe. With the strobe it gives a bus select that is either the bus the command came in on or the other bus of the redundant pair. If a new command arrives before the strobe, the pending reply is dropped and the new command is evaluated in its place. The host may rewrite table entries at any time while traffic is flowing.

Top module: `cmdword_filter`

## Requirements
- R1: The table key is the whole command word: terminal address in bits [15:11], transmit/receive in bit [10], subaddress in bits [9:5], word count or mode code in bits [4:0]. Two words that differ in any single bit have independent entries.
- R2: Action encoding: 2'b00 ignore, 2'b01 record only, 2'b10 reply only, 2'b11 record and reply. Bit 0 requests recording and bit 1 requests a reply.
- R3: At the edge that samples `cmd_valid`, `rec_en` takes bit 0 of the entry. It keeps that value until the edge that samples `eom`, where it goes low.
- R4: For a reply action, `reply_start` is high for exactly one cycle, exactly N = (4 + c) * 5 clock edges after the edge that samples `eom`. Here c is `dly_code` sampled at that edge.
- R5: A delay code above 62 (6'd63) behaves as 62, which is the longest delay (330 clocks).
- R6: While `reply_start` is high, `reply_bus` equals `cmd_bus` as sampled with the command, XOR `alt_bus` as sampled with `eom`. It holds that value until the next reply is scheduled.
- R7: A `cmd_valid` that arrives while a reply is still pending, either before or after its `eom`, cancels that reply. Only the new command's own entry can produce a strobe.
- R8: A table write takes effect for commands sampled on later edges. A command already accepted keeps the action it read, even if its entry is rewritten while the reply delay runs.
- R9: After reset, `rec_en`, `reply_start` and `reply_bus` are low and no reply is pending.
- R10: An `eom` with no reply pending produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 MHz nominal |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_wr | input | 1 | Host table write strobe |
| tbl_key | input | 16 | Command word whose entry is written |
| tbl_act | input | 2 | Action code written |
| cmd_valid | input | 1 | Decoded command word strobe |
| cmd_word | input | 16 | Decoded command word |
| cmd_bus | input | 1 | Bus the command was received on |
| eom | input | 1 | End of message, at the mid-parity crossing of the last word |
| dly_code | input | 6 | Reply delay code, 2 µs + code × 0.5 µs |
| alt_bus | input | 1 | 1: reply on the other bus of the pair |
| rec_en | output | 1 | Record the current message |
| reply_start | output | 1 | One-cycle strobe to start the status reply |
| reply_bus | output | 1 | Bus for the reply |

## Verification
A corrupted table row or a wrong slot select shows one cycle after the command strobe as a wrong `rec_en` level. It shows again at the end of the delay as a missing or unexpected reply strobe. A fault in the delay counter or the code clamp moves the strobe away from its exact clock edge, so the bench measures the delay to the cycle for every message. A cancel that fails leaves a stray strobe within 330 clocks of the interrupted message, and the bench watches for it over the full window.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
   localparam int CMD_W = 16;
   localparam int ACT_W = 2;

   typedef enum logic [ACT_W-1:0] {
      ACT_IGNORE = 2'b00,
      ACT_RECORD = 2'b01,
      ACT_REPLY  = 2'b10,
      ACT_BOTH   = 2'b11
   } act_e;

   function automatic logic wants_record(input logic [ACT_W-1:0] a);
      return a[0];
   endfunction

   function automatic logic wants_reply(input logic [ACT_W-1:0] a);
      return a[1];
   endfunction
endpackage

// File: rtl/cwf_table.sv
module cwf_table #(
   parameter int KEY_W     = 16,
   parameter int ACT_W     = 2,
   parameter int SLOT_BITS = 5
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [KEY_W-1:0] wr_key,
   input  logic [ACT_W-1:0] wr_act,
   input  logic [KEY_W-1:0] rd_key,
   output logic [ACT_W-1:0] rd_act
);
   localparam int ROW_BITS = KEY_W - SLOT_BITS;
   localparam int ROWS     = 1 << ROW_BITS;
   localparam int SLOTS    = 1 << SLOT_BITS;
   localparam int ROW_W    = SLOTS * ACT_W;

   if (SLOT_BITS < 0 || SLOT_BITS >= KEY_W) begin : g_bad_slots
      $error("cwf_table: SLOT_BITS must lie in 0..KEY_W-1");
   end
   if (ACT_W < 1) begin : g_bad_act
      $error("cwf_table: ACT_W must be positive");
   end

   if (SLOT_BITS == 0) begin : g_flat
      logic [ACT_W-1:0] mem [ROWS];
      always_ff @(posedge clk) begin
         if (wr_en) mem[wr_key] <= wr_act;
      end
      assign rd_act = mem[rd_key];
   end else begin : g_packed
      logic [ROW_W-1:0]     mem [ROWS];
      logic [ROW_W-1:0]     rd_row;
      logic [ROW_BITS-1:0]  wr_row, rd_rix;
      logic [SLOT_BITS-1:0] wr_slot, rd_slot;

      assign wr_row  = wr_key[KEY_W-1:SLOT_BITS];
      assign wr_slot = wr_key[SLOT_BITS-1:0];
      assign rd_rix  = rd_key[KEY_W-1:SLOT_BITS];
      assign rd_slot = rd_key[SLOT_BITS-1:0];

      always_ff @(posedge clk) begin
         if (wr_en) mem[wr_row][wr_slot*ACT_W +: ACT_W] <= wr_act;
      end

      assign rd_row = mem[rd_rix];
      assign rd_act = rd_row[rd_slot*ACT_W +: ACT_W];
   end
endmodule

// File: rtl/cwf_delay.sv
module cwf_delay #(
   parameter int CODE_W       = 6,
   parameter int CODE_MAX     = 62,
   parameter int BASE_STEPS   = 4,
   parameter int CLK_PER_STEP = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cancel,
   input  logic              load,
   input  logic [CODE_W-1:0] code,
   output logic              fire
);
   localparam int MAX_CYC = (BASE_STEPS + CODE_MAX) * CLK_PER_STEP;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (CODE_MAX >= (1 << CODE_W) || CODE_MAX < 0) begin : g_bad_code
      $error("cwf_delay: CODE_MAX does not fit CODE_W");
   end
   if (BASE_STEPS + CODE_MAX < 1 || CLK_PER_STEP < 1) begin : g_bad_len
      $error("cwf_delay: delay must be at least one clock");
   end

   logic [CODE_W-1:0] eff_code;
   logic [CNT_W-1:0]  load_val;
   logic [CNT_W-1:0]  cnt;
   logic              running;

   always_comb begin
      if (code > CODE_W'(CODE_MAX)) eff_code = CODE_W'(CODE_MAX);
      else                          eff_code = code;
      load_val = CNT_W'((BASE_STEPS + 32'(eff_code)) * CLK_PER_STEP - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
         fire    <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (cancel) begin
            running <= 1'b0;
            cnt     <= '0;
         end else if (load) begin
            running <= 1'b1;
            cnt     <= load_val;
         end else if (running) begin
            if (cnt == '0) begin
               fire    <= 1'b1;
               running <= 1'b0;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt < CNT_W'(MAX_CYC)));

   // R4
   fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

   // R10
   fire_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fire) |-> $past(running));
endmodule

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
   import cwf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [ACT_W-1:0] act,
   input  logic             rx_bus,
   input  logic             eom,
   input  logic             alt_bus,
   output logic             cancel,
   output logic             load,
   output logic             rec_en,
   output logic             reply_bus
);
   logic armed;
   logic bus_q;

   assign cancel = cmd_valid;
   assign load   = eom & armed & ~cmd_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_en    <= 1'b0;
         armed     <= 1'b0;
         bus_q     <= 1'b0;
         reply_bus <= 1'b0;
      end else if (cmd_valid) begin
         rec_en <= wants_record(act);
         armed  <= wants_reply(act);
         bus_q  <= rx_bus;
      end else if (eom) begin
         rec_en <= 1'b0;
         armed  <= 1'b0;
         if (armed) reply_bus <= bus_q ^ alt_bus;
      end
   end

   // R3
   rec_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rec_en) |-> $past(cmd_valid));

   // R3
   rec_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eom && !cmd_valid) |=> !rec_en);

   // R7
   arm_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !act[1]) |=> !armed);
endmodule

// File: rtl/cmdword_filter.sv
module cmdword_filter
   import cwf_pkg::*;
#(
   parameter int SLOT_BITS    = 5,
   parameter int CODE_W       = 6,
   parameter int CODE_MAX     = 62,
   parameter int BASE_STEPS   = 4,
   parameter int CLK_PER_STEP = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_wr,
   input  logic [CMD_W-1:0]  tbl_key,
   input  logic [ACT_W-1:0]  tbl_act,
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic              cmd_bus,
   input  logic              eom,
   input  logic [CODE_W-1:0] dly_code,
   input  logic              alt_bus,
   output logic              rec_en,
   output logic              reply_start,
   output logic              reply_bus
);
   logic [ACT_W-1:0] look_act;
   logic             cancel, load;

   cwf_table #(.KEY_W(CMD_W), .ACT_W(ACT_W), .SLOT_BITS(SLOT_BITS)) u_table (
      .clk    (clk),
      .wr_en  (tbl_wr),
      .wr_key (tbl_key),
      .wr_act (tbl_act),
      .rd_key (cmd_word),
      .rd_act (look_act)
   );

   cwf_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .act       (look_act),
      .rx_bus    (cmd_bus),
      .eom       (eom),
      .alt_bus   (alt_bus),
      .cancel    (cancel),
      .load      (load),
      .rec_en    (rec_en),
      .reply_bus (reply_bus)
   );

   cwf_delay #(
      .CODE_W(CODE_W), .CODE_MAX(CODE_MAX),
      .BASE_STEPS(BASE_STEPS), .CLK_PER_STEP(CLK_PER_STEP)
   ) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .cancel (cancel),
      .load   (load),
      .code   (dly_code),
      .fire   (reply_start)
   );

   // R7
   cmd_kills_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !reply_start);

   // R6
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reply_start |-> $stable(reply_bus));
endmodule

// File: tb/sim_cmdword_filter.sv
module sim_cmdword_filter;
   localparam time CLK_PERIOD = 100ns;
   localparam int  WINDOW     = 360;
   localparam int  NKEYS      = 16;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        tbl_wr = 1'b0, cmd_valid = 1'b0, cmd_bus = 1'b0, eom = 1'b0, alt_bus = 1'b0;
   logic [15:0] tbl_key = '0, cmd_word = '0;
   logic [1:0]  tbl_act = '0;
   logic [5:0]  dly_code = '0;
   logic        rec_en, reply_start, reply_bus;

   int checks = 0, fails = 0;
   logic [15:0] keys [NKEYS];
   logic [1:0]  acts [NKEYS];

   always #(CLK_PERIOD/2) clk = ~clk;

   cmdword_filter u0 (
      .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_key(tbl_key), .tbl_act(tbl_act),
      .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_bus(cmd_bus), .eom(eom),
      .dly_code(dly_code), .alt_bus(alt_bus),
      .rec_en(rec_en), .reply_start(reply_start), .reply_bus(reply_bus));

   function automatic int exp_cycles(input logic [5:0] c);
      int e = (c > 6'd62) ? 62 : int'(c);
      return (4 + e) * 5;
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic wr(input logic [15:0] k, input logic [1:0] a);
      tbl_key = k; tbl_act = a; tbl_wr = 1'b1;
      @(negedge clk); tbl_wr = 1'b0;
   endtask

   task automatic cmd(input logic [15:0] w, input logic bus);
      cmd_word = w; cmd_bus = bus; cmd_valid = 1'b1;
      @(negedge clk); cmd_valid = 1'b0;
   endtask

   // watch for the reply strobe after an eom edge; returns cycle index or 0
   task automatic watch(output int at, output logic bus);
      at = 0; bus = 1'b0;
      for (int i = 1; i <= WINDOW; i++) begin
         @(negedge clk);
         if (reply_start && at == 0) begin at = i; bus = reply_bus; end
      end
   endtask

   task automatic run_msg(input string req, input logic [15:0] w, input logic bus,
                          input logic [5:0] code, input logic alt, input logic [1:0] act);
      int at; logic rb;
      cmd(w, bus);
      check({req, " R3 rec_en after command"}, 32'(rec_en), 32'(act[0]));
      repeat (3) @(negedge clk);
      check({req, " R10 no strobe before eom"}, 32'(reply_start), 0);
      dly_code = code; alt_bus = alt; eom = 1'b1;
      @(negedge clk); eom = 1'b0;
      check({req, " R3 rec_en after eom"}, 32'(rec_en), 0);
      watch(at, rb);
      if (act[1]) begin
         check({req, " R4 reply delay"}, 32'(at), 32'(exp_cycles(code)));
         check({req, " R6 reply bus"}, 32'(rb), 32'(bus ^ alt));
      end else begin
         check({req, " R2 no reply"}, 32'(at), 0);
      end
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      int at; logic rb;
      void'($urandom(32'd1553));
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 rec_en", 32'(rec_en), 0);
      check("R9 reply_start", 32'(reply_start), 0);
      check("R9 reply_bus", 32'(reply_bus), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 eom with nothing pending
      eom = 1'b1; @(negedge clk); eom = 1'b0;
      watch(at, rb);
      check("R10 lone eom", 32'(at), 0);

      // R2 every action code
      wr(16'h0841, 2'b00); wr(16'h0842, 2'b01); wr(16'h0843, 2'b10); wr(16'h0844, 2'b11);
      run_msg("R2 ignore", 16'h0841, 1'b0, 6'd0, 1'b0, 2'b00);
      run_msg("R2 record", 16'h0842, 1'b0, 6'd0, 1'b0, 2'b01);
      run_msg("R2 reply",  16'h0843, 1'b1, 6'd0, 1'b0, 2'b10);
      run_msg("R2 both",   16'h0844, 1'b0, 6'd10, 1'b1, 2'b11);

      // R5 delay extremes and clamp
      run_msg("R5 code 62", 16'h0843, 1'b0, 6'd62, 1'b1, 2'b10);
      run_msg("R5 code 63", 16'h0843, 1'b1, 6'd63, 1'b1, 2'b10);

      // R1 single-bit neighbours of a reply key resolve on their own
      wr(16'hA5A5, 2'b10);
      for (int b = 0; b < 16; b += 5) wr(16'hA5A5 ^ (16'h1 << b), 2'b01);
      run_msg("R1 base key", 16'hA5A5, 1'b0, 6'd3, 1'b0, 2'b10);
      for (int b = 0; b < 16; b += 5)
         run_msg("R1 neighbour", 16'hA5A5 ^ (16'h1 << b), 1'b0, 6'd3, 1'b0, 2'b01);

      // R7 cancel after eom
      dly_code = 6'd20; alt_bus = 1'b0;
      cmd(16'h0843, 1'b0);
      eom = 1'b1; @(negedge clk); eom = 1'b0;
      repeat (10) @(negedge clk);
      run_msg("R7 cancel after eom", 16'h0841, 1'b0, 6'd20, 1'b0, 2'b00);
      // R7 cancel before eom
      cmd(16'h0844, 1'b1);
      repeat (4) @(negedge clk);
      run_msg("R7 cancel before eom", 16'h0842, 1'b0, 6'd5, 1'b0, 2'b01);
      // R7 replacement that itself replies times from its own eom
      cmd(16'h0843, 1'b0);
      eom = 1'b1; @(negedge clk); eom = 1'b0;
      repeat (7) @(negedge clk);
      run_msg("R7 replaced reply", 16'h0844, 1'b1, 6'd1, 1'b0, 2'b11);

      // R8 rewrite while delay runs: current reply kept, next command sees new entry
      dly_code = 6'd8; alt_bus = 1'b1;
      cmd(16'h0843, 1'b0);
      eom = 1'b1; @(negedge clk); eom = 1'b0;
      tbl_key = 16'h0843; tbl_act = 2'b00; tbl_wr = 1'b1;
      @(negedge clk); tbl_wr = 1'b0;
      at = 0;
      for (int i = 2; i <= WINDOW; i++) begin
         @(negedge clk);
         if (reply_start && at == 0) at = i;
      end
      check("R8 accepted command keeps reply", 32'(at), 32'(exp_cycles(6'd8)));
      run_msg("R8 new entry used", 16'h0843, 1'b0, 6'd8, 1'b1, 2'b00);

      // constrained random traffic
      for (int k = 0; k < NKEYS; k++) begin
         keys[k] = 16'(($urandom & 32'hFFE0) | k);
         acts[k] = 2'($urandom);
         wr(keys[k], acts[k]);
      end
      for (int n = 0; n < 40; n++) begin
         int k = int'($urandom % NKEYS);
         run_msg("R4 random", keys[k], 1'($urandom), 6'($urandom), 1'($urandom), acts[k]);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule